// File: doc/BRIEF.md
# Atomic-Update General-Purpose I/O Port

This block controls a port of general-purpose pins through a small memory-mapped register interface. Software writes an output latch and a direction register. It can also change chosen output bits in a single bus write through three write-only registers: one sets bits, one clears bits and one inverts bits. A read-only register returns the pin levels. Those levels are passed through a synchronizer and then gated by a per-pin digital-function qualifier and a port-level enable.

The bus has a write strobe, a read strobe, a word address, and write and read data of port width. Writes take effect at the rising clock edge. Read data is combinational and is valid in the same cycle as the read strobe. The parameter `IMPL_MASK` lists the pins that exist. Pins outside the mask never drive and always read as zero.

Top module: `pinport_ctrl`

## Requirements
- R1: After reset, the output latch, the direction register and the captured input are all zero, so `pin_oe` and `pin_out` are zero.
- R2: Word address 0 is the output latch and word address 5 is the direction register. Both can be read and written, and both read back the value last written.
- R3: A write to word address 1 sets to 1 each output latch bit whose write bit is 1. All other bits are unchanged.
- R4: A write to word address 2 clears to 0 each output latch bit whose write bit is 1. All other bits are unchanged.
- R5: A write to word address 3 inverts each output latch bit whose write bit is 1. All other bits are unchanged.
- R6: Reads of word addresses 1, 2 and 3 return zero.
- R7: `pin_oe` equals the direction register, where 1 means output. `pin_out` carries the output latch bit only where the direction bit is 1, and is 0 elsewhere.
- R8: Word address 4 returns the pin levels. A level that is held on `pin_in` reads back three rising edges later. A pin whose `pin_dig` bit is 0 reads 0.
- R9: While `port_en` is 0, the value read at word address 4 holds and does not follow the pins.
- R10: Bits outside `IMPL_MASK` are 0 on `pin_oe` and `pin_out` and in every register read.
- R11: Writes to word address 4 and to word addresses 6 and above change nothing. Reads of word addresses 6 and above return zero, and `rdata` is zero while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Word address |
| wdata | input | W | Write data |
| rdata | output | W | Read data (combinational) |
| pin_in | input | W | Raw pin levels |
| pin_dig | input | W | Per-pin digital-function qualifier |
| port_en | input | 1 | Input capture enable |
| pin_out | output | W | Pin drive value |
| pin_oe | output | W | Per-pin output enable |

## Verification
The bench builds the block with a width of 32 and an `IMPL_MASK` of 0x0FFF_FFFF. With the top four pins missing, all-ones writes to the output latch and the direction register, and all-ones levels on the pins, show whether the mask holds on every path. The default all-ones mask cannot show this. A reference model of the output latch in the bench follows every set, clear and toggle write. The input checks wait exactly three edges and then read, with both `pin_dig` and `port_en` varied.

// File: rtl/pinport_ctrl.sv
module pinport_ctrl #(
  parameter int          W         = 32,
  parameter int          AW        = 4,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [W-1:0]  pin_in,
  input  logic [W-1:0]  pin_dig,
  input  logic          port_en,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe
);

  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_SET  = AW'(1);
  localparam logic [AW-1:0] A_CLR  = AW'(2);
  localparam logic [AW-1:0] A_TOG  = AW'(3);
  localparam logic [AW-1:0] A_IN   = AW'(4);
  localparam logic [AW-1:0] A_DIR  = AW'(5);

  logic [W-1:0] out_q, dir_q, in_q, sync1_q, sync2_q;
  logic [W-1:0] wmask;

  assign wmask = wdata & IMPL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DATA:  out_q <= wmask;
        A_SET:   out_q <= out_q | wmask;
        A_CLR:   out_q <= out_q & ~wmask;
        A_TOG:   out_q <= out_q ^ wmask;
        A_DIR:   dir_q <= wmask;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      in_q    <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (port_en) in_q <= sync2_q & pin_dig & IMPL_MASK;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_DATA:  rdata = out_q;
        A_IN:    rdata = in_q;
        A_DIR:   rdata = dir_q;
        default: rdata = '0;
      endcase
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q & dir_q;

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> ((out_q & $past(wmask)) == $past(wmask)));

  assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> ((out_q & $past(wmask)) == '0));

  assert_tog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TOG) |=> (out_q == ($past(out_q) ^ $past(wmask))));

  assert_wo_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == A_SET || addr == A_CLR || addr == A_TOG)) |-> (rdata == '0));

  assert_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> $stable(in_q));

  assert_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe | pin_out | rdata) & ~IMPL_MASK) == '0);

  assert_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_IN || addr > A_DIR)) |=> ($stable(out_q) && $stable(dir_q)));

endmodule

// File: tb/pinport_ctrl_tb_top.sv
module pinport_ctrl_tb_top;
  localparam int W = 32;
  localparam int AW = 4;
  localparam logic [W-1:0] MASK = 32'h0FFF_FFFF;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, port_en = 0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0, pin_in = '0, pin_dig = '0;
  logic [W-1:0] rdata, pin_out, pin_oe;
  logic [W-1:0] m_out, m_dir, m_in;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pinport_ctrl #(.W(W), .AW(AW), .IMPL_MASK(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_dig(pin_dig),
    .port_en(port_en), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    @(negedge clk);
    addr = AW'(a); rd_en = 1;
    #2 d = rdata;
    rd_en = 0;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd(0, v); chk("R1 data", v, '0);
    rd(5, v); chk("R1 dir", v, '0);
    rd(4, v); chk("R1 in", v, '0);
    chk("R1 oe", pin_oe, '0);
    chk("R1 out", pin_out, '0);
  endtask

  task automatic t_rw();
    logic [W-1:0] v;
    wr(0, 32'hA5A5_5A5A); m_out = 32'hA5A5_5A5A & MASK;
    rd(0, v); chk("R2 data", v, m_out);
    wr(5, 32'h00FF_FF00); m_dir = 32'h00FF_FF00;
    rd(5, v); chk("R2 dir", v, m_dir);
    chk("R7 oe", pin_oe, m_dir);
    chk("R7 out", pin_out, m_out & m_dir);
  endtask

  task automatic t_atomic();
    logic [W-1:0] v;
    wr(1, 32'hF000_00F0); m_out = (m_out | 32'hF000_00F0) & MASK;
    rd(0, v); chk("R3 set", v, m_out);
    wr(2, 32'h0F0F_0002); m_out = m_out & ~32'h0F0F_0002;
    rd(0, v); chk("R4 clear", v, m_out);
    wr(3, 32'hFFFF_0000); m_out = (m_out ^ 32'hFFFF_0000) & MASK;
    rd(0, v); chk("R5 toggle", v, m_out);
    wr(3, 32'h0000_0000);
    rd(0, v); chk("R5 toggle zero", v, m_out);
    chk("R7 out", pin_out, m_out & m_dir);
    rd(1, v); chk("R6 set reads 0", v, '0);
    rd(2, v); chk("R6 clear reads 0", v, '0);
    rd(3, v); chk("R6 toggle reads 0", v, '0);
  endtask

  task automatic t_mask();
    logic [W-1:0] v;
    wr(0, '1); wr(5, '1); m_out = MASK; m_dir = MASK;
    chk("R10 oe", pin_oe, MASK);
    chk("R10 out", pin_out, MASK);
    rd(0, v); chk("R10 data", v, MASK);
    rd(5, v); chk("R10 dir", v, MASK);
  endtask

  task automatic t_input();
    logic [W-1:0] v;
    @(negedge clk);
    port_en = 1; pin_in = 32'hFFFF_1234; pin_dig = 32'hFFFF_00FF;
    m_in = 32'hFFFF_1234 & 32'hFFFF_00FF & MASK;
    @(negedge clk);
    @(negedge clk);
    addr = AW'(4); rd_en = 1; #2 v = rdata; rd_en = 0;
    chk("R8 not before third edge", v, '0);
    @(negedge clk);
    addr = AW'(4); rd_en = 1; #2 v = rdata; rd_en = 0;
    chk("R8 input", v, m_in);
    @(negedge clk);
    port_en = 0; pin_in = 32'h0000_5A5A; pin_dig = '1;
    repeat (5) @(negedge clk);
    rd(4, v); chk("R9 hold", v, m_in);
    @(negedge clk); port_en = 1;
    m_in = 32'h0000_5A5A;
    repeat (2) @(negedge clk);
    rd(4, v); chk("R9 resume", v, m_in);
  endtask

  task automatic t_ignore();
    logic [W-1:0] v;
    wr(0, 32'h0123_4567); m_out = 32'h0123_4567;
    wr(4, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    wr(15, 32'h0000_0000);
    rd(0, v); chk("R11 data kept", v, m_out);
    rd(5, v); chk("R11 dir kept", v, m_dir);
    rd(4, v); chk("R11 in kept", v, m_in);
    rd(6, v); chk("R11 unmapped read", v, '0);
    rd(15, v); chk("R11 unmapped read", v, '0);
    @(negedge clk); addr = AW'(0); #2 chk("R11 no strobe", rdata, '0);
  endtask

  initial begin
    m_out = '0; m_dir = '0; m_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rw();
    t_atomic();
    t_mask();
    t_input();
    t_ignore();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule